// File: doc/BRIEF.md
# Debug Port Status and Sequencing Unit

This unit sits between an external debug tool, which shifts words in serially, and a CPU halted in debug mode. The tool delivers one tagged word per transmission, marked as an instruction, a data word or a port command. The CPU asks the port for work by issuing either an instruction fetch or a data read. The unit pairs each CPU request with the next accepted word of the matching kind. When the kinds disagree it ends the request with a bus error. Command words are handed to the port's command logic and never reach the CPU.

On every transmission strobe the unit loads the 2-bit status that goes back to the tool during the next transmission. It ranks the pending conditions so that several of them are reported one after another over consecutive transmissions. Any word that arrives while an error or interrupt status is being shifted out is dropped. The CPU request that is waiting stays open and is answered by the next accepted word of the right kind.

The CPU request channel is valid/ready: the unit holds at most one request and keeps ready low until that request has been answered, so the CPU stalls there. The tool side has no back-pressure, because a serial debug tool cannot be stalled. Words the unit cannot take are dropped, as stated below. The response, command, write and interrupt signals are single-cycle pulses with no handshake.

Top module: `dbg_stat_port`

## Requirements
- R1: After reset, st_code is 00 (null), st_data is zero, cpu_req_ready is 1, and no response or command pulse is produced.
- R2: st_code and st_data change only in the cycle after a sh_valid strobe and hold their value at all other times.
- R3: Status encoding and ranking, highest first:
  - sequencing error = 10;
  - valid data = 01;
  - interrupt = 11;
  - null = 00 when no condition is pending.

  Each pending condition is cleared only by the strobe that reports it. A condition raised in the same cycle as a strobe stays pending for a later strobe.
- R4: When st_code is 01, st_data carries the last word the CPU wrote with cpu_wr_valid. For any other code st_data is zero.
- R5: A fetch (cpu_req_type=0) paired with an instruction (tag 00), or a read (cpu_req_type=1) paired with a data word (tag 01), gives one cpu_rsp_valid pulse with cpu_rsp_data equal to the word and cpu_rsp_berr=0.
- R6: A fetch paired with a data word, or a read paired with an instruction, gives one cpu_rsp_valid pulse with cpu_rsp_berr=1 and zero data, and it makes a sequencing error pending.
- R7: A word of any tag whose strobe falls while st_code is 10 or 11 is dropped. An outstanding CPU request is neither answered nor lost, and the next accepted matching word answers it.
- R8: While an accepted instruction or data word is still waiting for a CPU request, any further word is dropped, and the waiting word is kept unchanged.
- R9: A word tagged 10 or 11 (command or trap-enable) that is accepted gives one cmd_valid pulse carrying the word, and no CPU response.
- R10: cpu_req_ready is 1 exactly when no request is outstanding. It is high again by the cycle in which the response pulse appears.
- R11: A cpu_irq pulse makes an interrupt status (11) pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sh_valid | input | 1 | One-cycle strobe: a transmission completed |
| sh_tag | input | 2 | Tag of shifted word: 00 instruction, 01 data, 1x command |
| sh_word | input | W | Word shifted in by the tool |
| st_code | output | 2 | Status for the transmission now starting |
| st_data | output | W | Data word to shift out with the status |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_type | input | 1 | 0 instruction fetch, 1 data read |
| cpu_req_ready | output | 1 | Unit can accept a request |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_data | output | W | Response word (zero on bus error) |
| cpu_rsp_berr | output | 1 | Response ends with bus error |
| cpu_wr_valid | input | 1 | CPU moves a word into the port |
| cpu_wr_data | input | W | Word moved by the CPU |
| cpu_irq | input | 1 | CPU took an exception in debug mode |
| cmd_valid | output | 1 | One-cycle pulse: command word accepted |
| cmd_word | output | W | Accepted command word |

## Verification
The bench pairs every request kind with every word kind. A swapped match rule would answer a mismatched read with data instead of a bus error. The bench also stacks sequencing error, valid data and interrupt so that all three are pending together. A wrong ranking, or a flag that is cleared too early, then puts the codes in the wrong order or loses one of them. Words are shifted in during error transmissions while a fetch is waiting. A unit that does not drop them would answer the fetch with a stale instruction, and one that drops the request would hang the CPU. Finally, a write that lands in the same cycle as a strobe, and a second word sent while the buffer is full, expose set/clear races and buffer overwrites.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [1:0] {
    ST_NULL   = 2'b00,
    ST_VALID  = 2'b01,
    ST_SEQERR = 2'b10,
    ST_INTR   = 2'b11
  } dsr_code_e;

  typedef enum logic [1:0] {
    TG_INSN = 2'b00,
    TG_DATA = 2'b01,
    TG_CMD  = 2'b10,
    TG_TRAP = 2'b11
  } dsr_tag_e;

  localparam logic REQ_FETCH = 1'b0;
  localparam logic REQ_READ  = 1'b1;
endpackage

// File: rtl/dsr_inbuf.sv
module dsr_inbuf #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sh_valid,
  input  logic [1:0]   sh_tag,
  input  logic [W-1:0] sh_word,
  input  logic         ignore,
  input  logic         take,
  output logic         buf_v,
  output logic [1:0]   buf_tag,
  output logic [W-1:0] buf_word
);
  logic accept;
  // a word is taken only outside error reporting and into an empty slot
  assign accept = sh_valid && !ignore && !buf_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_v    <= 1'b0;
      buf_tag  <= 2'b00;
      buf_word <= '0;
    end else begin
      if (take) buf_v <= 1'b0;
      if (accept) begin
        buf_v    <= 1'b1;
        buf_tag  <= sh_tag;
        buf_word <= sh_word;
      end
    end
  end

  AST_DROP_WHILE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    sh_valid && ignore && !buf_v |=> !buf_v); // R7
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_v && !take |=> buf_v && $stable(buf_word)); // R8
endmodule

// File: rtl/dsr_match.sv
module dsr_match
  import dsr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_type,
  output logic         req_ready,
  input  logic         buf_v,
  input  logic [1:0]   buf_tag,
  input  logic [W-1:0] buf_word,
  output logic         take,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_data,
  output logic         rsp_berr,
  output logic         cmd_valid,
  output logic [W-1:0] cmd_word
);
  logic out_v;
  logic out_type;
  logic is_cmd;
  logic hit;
  logic mism;

  assign is_cmd    = buf_v && buf_tag[1];
  assign hit       = buf_v && !buf_tag[1] && out_v;
  // fetch must meet an instruction, read must meet data
  assign mism      = (out_type == REQ_READ) != (buf_tag == TG_DATA);
  assign take      = is_cmd || hit;
  assign req_ready = !out_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v     <= 1'b0;
      out_type  <= REQ_FETCH;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_berr  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
    end else begin
      if (req_valid && req_ready) begin
        out_v    <= 1'b1;
        out_type <= req_type;
      end else if (hit) begin
        out_v <= 1'b0;
      end
      rsp_valid <= hit;
      rsp_berr  <= hit && mism;
      rsp_data  <= (hit && !mism) ? buf_word : '0;
      cmd_valid <= is_cmd;
      cmd_word  <= is_cmd ? buf_word : '0;
    end
  end

  AST_READY_AT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R10
  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(out_v)); // R5
  AST_BERR_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_berr |-> rsp_valid && rsp_data == '0); // R6
  AST_CMD_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rsp_valid); // R9
endmodule

// File: rtl/dsr_status.sv
module dsr_status
  import dsr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sh_valid,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         irq,
  input  logic         berr_evt,
  output logic [1:0]   code,
  output logic [W-1:0] st_data,
  output logic         ignore
);
  logic      dat_q, seq_q, irq_q;
  logic [W-1:0] dbuf;
  dsr_code_e pick;
  logic      clr_dat, clr_seq, clr_irq;

  always_comb begin
    if (seq_q)      pick = ST_SEQERR;
    else if (dat_q) pick = ST_VALID;
    else if (irq_q) pick = ST_INTR;
    else            pick = ST_NULL;
  end

  assign clr_seq = sh_valid && (pick == ST_SEQERR);
  assign clr_dat = sh_valid && (pick == ST_VALID);
  assign clr_irq = sh_valid && (pick == ST_INTR);
  // both error codes have the top bit set
  assign ignore  = code[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q   <= 1'b0;
      seq_q   <= 1'b0;
      irq_q   <= 1'b0;
      dbuf    <= '0;
      code    <= ST_NULL;
      st_data <= '0;
    end else begin
      // a new event wins over a clear in the same cycle
      dat_q <= wr_valid || (dat_q && !clr_dat);
      seq_q <= berr_evt || (seq_q && !clr_seq);
      irq_q <= irq      || (irq_q && !clr_irq);
      if (wr_valid) dbuf <= wr_data;
      if (sh_valid) begin
        code    <= pick;
        st_data <= (pick == ST_VALID) ? dbuf : '0;
      end
    end
  end

  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_valid |=> $stable(code) && $stable(st_data)); // R2
  AST_SEQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    sh_valid && seq_q |=> code == ST_SEQERR); // R3
  AST_DATA_BEFORE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    sh_valid && dat_q && !seq_q |=> code == ST_VALID); // R3
  AST_BERR_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    berr_evt |=> seq_q); // R6
  AST_IRQ_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq_q); // R11
  AST_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    code != ST_VALID |-> st_data == '0); // R4
endmodule

// File: rtl/dbg_stat_port.sv
module dbg_stat_port #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sh_valid,
  input  logic [1:0]   sh_tag,
  input  logic [W-1:0] sh_word,
  output logic [1:0]   st_code,
  output logic [W-1:0] st_data,
  input  logic         cpu_req_valid,
  input  logic         cpu_req_type,
  output logic         cpu_req_ready,
  output logic         cpu_rsp_valid,
  output logic [W-1:0] cpu_rsp_data,
  output logic         cpu_rsp_berr,
  input  logic         cpu_wr_valid,
  input  logic [W-1:0] cpu_wr_data,
  input  logic         cpu_irq,
  output logic         cmd_valid,
  output logic [W-1:0] cmd_word
);
  logic         ignore;
  logic         take;
  logic         buf_v;
  logic [1:0]   buf_tag;
  logic [W-1:0] buf_word;

  dsr_inbuf #(.W(W)) u_inbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .sh_valid (sh_valid),
    .sh_tag   (sh_tag),
    .sh_word  (sh_word),
    .ignore   (ignore),
    .take     (take),
    .buf_v    (buf_v),
    .buf_tag  (buf_tag),
    .buf_word (buf_word)
  );

  dsr_match #(.W(W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (cpu_req_valid),
    .req_type  (cpu_req_type),
    .req_ready (cpu_req_ready),
    .buf_v     (buf_v),
    .buf_tag   (buf_tag),
    .buf_word  (buf_word),
    .take      (take),
    .rsp_valid (cpu_rsp_valid),
    .rsp_data  (cpu_rsp_data),
    .rsp_berr  (cpu_rsp_berr),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word)
  );

  dsr_status #(.W(W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .sh_valid (sh_valid),
    .wr_valid (cpu_wr_valid),
    .wr_data  (cpu_wr_data),
    .irq      (cpu_irq),
    .berr_evt (cpu_rsp_berr),
    .code     (st_code),
    .st_data  (st_data),
    .ignore   (ignore)
  );

  AST_RESET_NULL: assert property (@(posedge clk)
    !rst_n |=> st_code == 2'b00 && cpu_req_ready && !cpu_rsp_valid && !cmd_valid); // R1
endmodule

// File: tb/dbg_stat_port_bench.sv
module dbg_stat_port_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sh_valid = 1'b0;
  logic [1:0]   sh_tag = 2'b00;
  logic [W-1:0] sh_word = '0;
  logic [1:0]   st_code;
  logic [W-1:0] st_data;
  logic         cpu_req_valid = 1'b0;
  logic         cpu_req_type = 1'b0;
  logic         cpu_req_ready;
  logic         cpu_rsp_valid;
  logic [W-1:0] cpu_rsp_data;
  logic         cpu_rsp_berr;
  logic         cpu_wr_valid = 1'b0;
  logic [W-1:0] cpu_wr_data = '0;
  logic         cpu_irq = 1'b0;
  logic         cmd_valid;
  logic [W-1:0] cmd_word;

  always #10 clk = ~clk;

  dbg_stat_port #(.W(W)) u_dbg_stat_port (
    .clk(clk), .rst_n(rst_n), .sh_valid(sh_valid), .sh_tag(sh_tag), .sh_word(sh_word),
    .st_code(st_code), .st_data(st_data), .cpu_req_valid(cpu_req_valid),
    .cpu_req_type(cpu_req_type), .cpu_req_ready(cpu_req_ready),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data), .cpu_rsp_berr(cpu_rsp_berr),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_data(cpu_wr_data), .cpu_irq(cpu_irq),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // pulse monitor
  int           rsp_n = 0;
  int           cmd_n = 0;
  logic [W-1:0] rsp_last = '0;
  logic         berr_last = 1'b0;
  logic [W-1:0] cmd_last = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (cpu_rsp_valid) begin
        rsp_n++;
        rsp_last  = cpu_rsp_data;
        berr_last = cpu_rsp_berr;
      end
      if (cmd_valid) begin
        cmd_n++;
        cmd_last = cmd_word;
      end
    end
  end

  // transaction-level model of the pending conditions
  bit           m_dat = 0, m_seq = 0, m_irq = 0;
  logic [W-1:0] m_dbuf = '0;
  logic [1:0]   m_code = 2'b00;

  function automatic logic [1:0] exp_pick(bit s, bit d, bit i);
    if (s) return 2'b10;
    if (d) return 2'b01;
    if (i) return 2'b11;
    return 2'b00;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift(input logic [1:0] tg, input logic [W-1:0] w, input bit cowr,
                       input logic [W-1:0] cod, output bit dropped);
    logic [1:0]   nc;
    logic [W-1:0] nd;
    @(negedge clk);
    sh_valid = 1'b1; sh_tag = tg; sh_word = w;
    cpu_wr_valid = cowr; cpu_wr_data = cod;
    @(negedge clk);
    sh_valid = 1'b0; cpu_wr_valid = 1'b0;
    dropped = m_code[1];
    nc = exp_pick(m_seq, m_dat, m_irq);
    nd = (nc == 2'b01) ? m_dbuf : '0;
    if (nc == 2'b10) m_seq = 0;
    else if (nc == 2'b01) m_dat = 0;
    else if (nc == 2'b11) m_irq = 0;
    if (cowr) begin m_dat = 1; m_dbuf = cod; end
    m_code = nc;
    chk(st_code == nc, "R3 status code", 64'(st_code), 64'(nc));
    chk(st_data == nd, "R4 status data", 64'(st_data), 64'(nd));
  endtask

  task automatic do_req(input logic t);
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R10 ready when idle", 64'(cpu_req_ready), 64'd1);
    cpu_req_valid = 1'b1; cpu_req_type = t;
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic cpu_write(input logic [W-1:0] d);
    @(negedge clk);
    cpu_wr_valid = 1'b1; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_valid = 1'b0;
    m_dat = 1; m_dbuf = d;
  endtask

  task automatic cpu_int();
    @(negedge clk);
    cpu_irq = 1'b1;
    @(negedge clk);
    cpu_irq = 1'b0;
    m_irq = 1;
  endtask

  task automatic drain();
    bit dr;
    int c0, r0;
    logic [W-1:0] cw;
    while (m_dat || m_seq || m_irq || m_code != 2'b00) begin
      c0 = cmd_n; r0 = rsp_n; cw = $urandom;
      shift(2'b10, cw, 1'b0, '0, dr);
      idle(3);
      if (dr) chk(cmd_n == c0, "R7 command dropped in error slot", 64'(cmd_n), 64'(c0));
      else begin
        chk(cmd_n == c0 + 1, "R9 command pulse", 64'(cmd_n), 64'(c0 + 1));
        chk(cmd_last == cw, "R9 command word", 64'(cmd_last), 64'(cw));
      end
      chk(rsp_n == r0, "R9 no CPU response for command", 64'(rsp_n), 64'(r0));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit dr;
    int r0, c0;
    logic [W-1:0] code_hold;
    void'($urandom(32'd1234));
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(st_code == 2'b00, "R1 reset code", 64'(st_code), 64'd0);
    chk(st_data == '0, "R1 reset data", 64'(st_data), 64'd0);
    chk(cpu_req_ready == 1'b1, "R1 reset ready", 64'(cpu_req_ready), 64'd1);
    chk(rsp_n == 0 && cmd_n == 0, "R1 no pulses", 64'(rsp_n + cmd_n), 64'd0);

    // R3 write coinciding with a strobe stays pending
    shift(2'b10, 32'h11, 1'b1, 32'hCAFE0001, dr);
    shift(2'b10, 32'h12, 1'b0, '0, dr);
    idle(2);
    // R2 code holds without strobe
    code_hold = 32'(st_code);
    idle(5);
    chk(32'(st_code) == code_hold, "R2 code held", 64'(st_code), 64'(code_hold));
    drain();

    // R7 words dropped during error transmissions, fetch stays open
    do_req(1'b0);
    shift(2'b01, 32'hBAD0, 1'b0, '0, dr);
    idle(3);
    chk(berr_last == 1'b1, "R6 fetch vs data bus error", 64'(berr_last), 64'd1);
    m_seq = 1;
    cpu_int();
    do_req(1'b0);
    shift(2'b10, 32'h5, 1'b0, '0, dr);           // starts seq error slot
    r0 = rsp_n;
    shift(2'b00, 32'hAAAA, 1'b0, '0, dr);        // dropped, starts irq slot
    shift(2'b00, 32'hBBBB, 1'b0, '0, dr);        // dropped, starts null slot
    idle(3);
    chk(rsp_n == r0, "R7 no response for dropped words", 64'(rsp_n), 64'(r0));
    chk(cpu_req_ready == 1'b0, "R7 request still outstanding", 64'(cpu_req_ready), 64'd0);
    shift(2'b00, 32'hCCCC, 1'b0, '0, dr);
    idle(3);
    chk(rsp_n == r0 + 1, "R7 later word answers", 64'(rsp_n), 64'(r0 + 1));
    chk(rsp_last == 32'hCCCC && !berr_last, "R7 answered with accepted word", 64'(rsp_last), 64'hCCCC);
    chk(cpu_req_ready == 1'b1, "R10 ready after response", 64'(cpu_req_ready), 64'd1);

    // R8 occupied buffer drops further words
    r0 = rsp_n; c0 = cmd_n;
    shift(2'b00, 32'h1111, 1'b0, '0, dr);
    shift(2'b00, 32'h2222, 1'b0, '0, dr);
    shift(2'b10, 32'h3333, 1'b0, '0, dr);
    idle(2);
    do_req(1'b0);
    idle(6);
    chk(rsp_n == r0 + 1, "R8 one response", 64'(rsp_n), 64'(r0 + 1));
    chk(rsp_last == 32'h1111, "R8 first word kept", 64'(rsp_last), 64'h1111);
    chk(cmd_n == c0, "R8 command dropped while full", 64'(cmd_n), 64'(c0));

    // random pairings
    for (int i = 0; i < 60; i++) begin
      logic         t;
      logic [1:0]   tg;
      logic [W-1:0] w;
      bit           mism;
      t  = 1'($urandom % 2);
      tg = 2'($urandom % 2);
      w  = $urandom;
      do_req(t);
      if ($urandom % 2) cpu_write($urandom);
      r0 = rsp_n;
      shift(tg, w, 1'b0, '0, dr);
      idle(3);
      chk(rsp_n == r0 + 1, "R5 one response", 64'(rsp_n), 64'(r0 + 1));
      mism = (t == 1'b1) != (tg == 2'b01);
      if (!mism) begin
        chk(rsp_last == w && !berr_last, "R5 matched word", 64'(rsp_last), 64'(w));
      end else begin
        chk(berr_last && rsp_last == '0, "R6 mismatch bus error", 64'(berr_last), 64'd1);
        m_seq = 1;
        cpu_int();
      end
      if ($urandom % 2) cpu_write($urandom);
      if ($urandom % 3 == 0) cpu_int();
      drain();
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule